// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Controller

This block is a hardware master for a small serial EEPROM of 64 words of 16 bits each. The EEPROM is reached over four wires: chip select, serial clock, a data line into the device and a data line out of it. A host issues one command at a time through a request port. The command is either a read of one word or a write of one word, with a 6-bit word address. The controller then builds the whole pin-level exchange on its own and reports the result on a response port.

Every pin change is held for one settle interval of `SETTLE` system clock cycles before the next change. A write is wrapped in a write-enable command and a write-disable command. After the data of a write, the controller polls the device data line for a ready level. The number of polls is bounded, and the response carries a timeout flag if the device never reports ready. The request port is valid/ready. A request must hold `req_write`, `req_addr` and `req_wdata` stable while `req_valid` is high and `req_ready` is low. It is taken on the first rising clock edge where both are high. `req_ready` is low for the whole of a command, so the block never takes a second request early. The response port has no back-pressure: `rsp_valid` is a single-cycle pulse, and the consumer must take `rsp_rdata` and `rsp_timeout` in that cycle. `rsp_rdata` has meaning only for reads.

Top module: `mw_eeprom_ctrl`

## Requirements
- R1: A request is taken only on an edge where `req_valid` and `req_ready` are both high. `req_ready` is low from that edge until `rsp_valid` pulses. A request raised while the block is busy has no effect on the device or on the response.
- R2: A read shifts out the 3-bit read opcode (default 110), then the 6-bit address, most significant bit first. It then shifts in 16 bits, most significant first, each one sampled while the serial clock is high. `rsp_rdata` returns the word.
- R3: A write first shifts out a 9-bit enable command: the 5-bit enable opcode (default 10011) followed by four 0 bits. It then runs a standby sequence. It then shifts out the write opcode (default 101), the 6-bit address and the 16 data bits as one 25-bit MSB-first stream. The device then holds the written word.
- R4: After the write data, the block runs a standby sequence and then samples the device data line once per interval, up to `POLL_MAX` times. A high sample ends the wait early. If no sample is high, `rsp_timeout` is 1 with the response.
- R5: After the wait, the block runs a standby sequence, then a 9-bit disable command (opcode 10000 followed by four 0 bits). It then drops chip select and the data line and gives one full clock pulse. At the write's response, chip select, clock and data line are all low. Chip select only ever falls while the clock is low.
- R6: A read ends with a standby sequence: chip select low, clock high, chip select high, clock low. At the read's response, chip select is high and the clock is low.
- R7: The data line to the device is low after each shift-out stream and throughout the receive of read data.
- R8: A read's response is due exactly 66 × `SETTLE` cycles after the accepting edge. A write's response is due exactly (149 + p) × `SETTLE` cycles after it, where p is the number of poll samples taken.
- R9: `rsp_valid` is high for exactly one cycle per command, and `req_ready` is high in that same cycle. `rsp_timeout` is 0 for every read and for every write that saw a ready sample.
- R10: A synchronous active-high reset drives chip select, clock, data line, `busy` and `rsp_valid` low, and leaves `req_ready` high.
- R11: Each serial clock level is held for at least `SETTLE` cycles. The data line to the device changes only while the clock is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken (block idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (6) | Word address |
| req_wdata | input | DATA_W (16) | Word to write |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W (16) | Word read (valid with a read's response) |
| rsp_timeout | output | 1 | Write completion was never seen |
| busy | output | 1 | Command in progress |
| ee_cs | output | 1 | Device chip select |
| ee_sk | output | 1 | Device serial clock |
| ee_di | output | 1 | Serial data to the device |
| ee_do | input | 1 | Serial data from the device |

## Verification
Each command's completion is fixed by arithmetic on the settle interval. A read completes 66 intervals after acceptance. A write completes 149 intervals plus one interval per poll sample after acceptance. The bench's device model becomes ready a known number of cycles after the commit, so p is 3 in normal writes and equals `POLL_MAX` in the timeout case. The bench counts rising edges from the accepting edge and samples at the falling edge that follows each of them. The response must appear at the predicted count, and it must be gone one cycle later. Pin levels at completion, and the word held in the device model, are checked at that same falling edge.

// File: rtl/mw_pkg.sv
package mw_pkg;
  localparam int PC_W = 4;

  typedef enum logic [2:0] {
    SEG_SETUP,
    SEG_SEND,
    SEG_RECV,
    SEG_STBY,
    SEG_POLL,
    SEG_CLEAN,
    SEG_END
  } seg_e;
endpackage

// File: rtl/mw_tick.sv
module mw_tick #(
  parameter int DIV = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign tick = en && (cnt == LAST);

  generate
    if (DIV > 1) begin : g_spacing
      // R11: interval boundaries never fall on adjacent cycles
      a_r11_tick_spacing: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/mw_prog.sv
module mw_prog import mw_pkg::*; #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int FW = 25,
  parameter int LW = 5,
  parameter logic [2:0] OP_RD  = 3'b110,
  parameter logic [2:0] OP_WR  = 3'b101,
  parameter logic [4:0] OP_EN  = 5'b10011,
  parameter logic [4:0] OP_DIS = 5'b10000
) (
  input  logic              is_wr,
  input  logic [PC_W-1:0]   pc,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output seg_e              seg,
  output logic [FW-1:0]     bits,
  output logic [LW-1:0]     len
);
  localparam logic [LW-1:0] LEN_CMD  = LW'(ADDR_W + 3);
  localparam logic [LW-1:0] LEN_FULL = LW'(FW);

  always_comb begin
    seg  = SEG_END;
    bits = '0;
    len  = '0;
    if (!is_wr) begin
      case (pc)
        4'd0: seg = SEG_SETUP;
        4'd1: begin
          seg  = SEG_SEND;
          bits = {OP_RD, addr, {DATA_W{1'b0}}};
          len  = LEN_CMD;
        end
        4'd2: seg = SEG_RECV;
        4'd3: seg = SEG_STBY;
        default: seg = SEG_END;
      endcase
    end else begin
      case (pc)
        4'd0: seg = SEG_SETUP;
        4'd1: begin
          seg  = SEG_SEND;
          bits = {OP_EN, {(FW-5){1'b0}}};
          len  = LEN_CMD;
        end
        4'd2: seg = SEG_STBY;
        4'd3: begin
          seg  = SEG_SEND;
          bits = {OP_WR, addr, wdata};
          len  = LEN_FULL;
        end
        4'd4: seg = SEG_STBY;
        4'd5: seg = SEG_POLL;
        4'd6: seg = SEG_STBY;
        4'd7: begin
          seg  = SEG_SEND;
          bits = {OP_DIS, {(FW-5){1'b0}}};
          len  = LEN_CMD;
        end
        4'd8: seg = SEG_CLEAN;
        default: seg = SEG_END;
      endcase
    end
  end
endmodule

// File: rtl/mw_engine.sv
module mw_engine import mw_pkg::*; #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int FW = 25,
  parameter int LW = 5,
  parameter int SETTLE = 50,
  parameter int POLL_MAX = 200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              ee_do,
  input  seg_e              nseg,
  input  logic [FW-1:0]     nbits,
  input  logic [LW-1:0]     nlen,
  output logic              busy,
  output logic              is_wr,
  output logic [PC_W-1:0]   pc_nx,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              tout,
  output logic              cs,
  output logic              sk,
  output logic              di
);
  localparam int QW = (POLL_MAX > 1) ? $clog2(POLL_MAX) : 1;
  localparam logic [QW-1:0] POLL_LAST = QW'(POLL_MAX - 1);

  seg_e            seg_q;
  logic [PC_W-1:0] pc_q;
  logic [1:0]      ph;
  logic [LW-1:0]   bitn;
  logic [FW-1:0]   sreg;
  logic [QW-1:0]   polls;
  logic            do_q;
  logic            seg_last;

  assign pc_nx = pc_q + 1'b1;

  always_comb begin
    case (seg_q)
      SEG_SETUP: seg_last = (ph == 2'd1);
      SEG_SEND:  seg_last = (ph == 2'd3);
      SEG_RECV:  seg_last = (ph == 2'd1) && (bitn == '0);
      SEG_STBY:  seg_last = (ph == 2'd3);
      SEG_POLL:  seg_last = do_q || (polls == POLL_LAST);
      SEG_CLEAN: seg_last = (ph == 2'd2);
      default:   seg_last = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; is_wr <= 1'b0; pc_q <= '0; seg_q <= SEG_SETUP;
      addr <= '0; wdata <= '0; ph <= '0; bitn <= '0; sreg <= '0;
      polls <= '0; do_q <= 1'b0; done <= 1'b0; rdata <= '0; tout <= 1'b0;
      cs <= 1'b0; sk <= 1'b0; di <= 1'b0;
    end else begin
      done <= 1'b0;
      do_q <= ee_do;
      if (!busy) begin
        if (req_valid) begin
          busy  <= 1'b1;
          is_wr <= req_write;
          addr  <= req_addr;
          wdata <= req_wdata;
          pc_q  <= '0;
          seg_q <= SEG_SETUP;
          ph    <= '0;
          tout  <= 1'b0;
          sk    <= 1'b0;
          di    <= 1'b0;
        end
      end else if (tick) begin
        if (seg_last) begin
          pc_q  <= pc_nx;
          seg_q <= nseg;
          ph    <= '0;
          if (seg_q == SEG_POLL && !do_q) tout <= 1'b1;
          case (nseg)
            SEG_SETUP: begin sk <= 1'b0; di <= 1'b0; end
            SEG_SEND: begin
              sreg <= nbits;
              bitn <= nlen - 1'b1;
              di   <= nbits[FW-1];
            end
            SEG_RECV: begin sk <= 1'b1; bitn <= LW'(DATA_W - 1); end
            SEG_STBY: begin cs <= 1'b0; sk <= 1'b0; end
            SEG_POLL: polls <= '0;
            SEG_CLEAN: begin cs <= 1'b0; di <= 1'b0; end
            default: begin busy <= 1'b0; done <= 1'b1; end
          endcase
        end else begin
          ph <= ph + 2'd1;
          case (seg_q)
            SEG_SETUP: cs <= 1'b1;
            SEG_SEND: begin
              if (ph == 2'd0) sk <= 1'b1;
              else if (ph == 2'd1) sk <= 1'b0;
              else if (bitn == '0) di <= 1'b0;
              else begin
                sreg <= sreg << 1;
                di   <= sreg[FW-2];
                bitn <= bitn - 1'b1;
                ph   <= 2'd0;
              end
            end
            SEG_RECV: begin
              if (ph == 2'd0) begin
                sk    <= 1'b0;
                rdata <= {rdata[DATA_W-2:0], do_q};
              end else begin
                sk   <= 1'b1;
                bitn <= bitn - 1'b1;
                ph   <= 2'd0;
              end
            end
            SEG_STBY: begin
              if (ph == 2'd0) sk <= 1'b1;
              else if (ph == 2'd1) cs <= 1'b1;
              else sk <= 1'b0;
            end
            SEG_POLL: polls <= polls + 1'b1;
            SEG_CLEAN: begin
              if (ph == 2'd0) sk <= 1'b1;
              else sk <= 1'b0;
            end
            default: ;
          endcase
        end
      end
    end
  end

  // R9: completion is a single-cycle pulse
  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R7: data line held low while read data comes in
  a_r7_di_low_recv: assert property (@(posedge clk) disable iff (rst)
    (busy && seg_q == SEG_RECV) |-> !di);
  // R11: data line only moves while the clock is low
  a_r11_di_steady: assert property (@(posedge clk) disable iff (rst)
    sk |-> $stable(di));
  // R5: chip select falls only with the clock low
  a_r5_cs_fall_sk_low: assert property (@(posedge clk) disable iff (rst)
    $fell(cs) |-> !sk);
  // R4: a timeout can only come from a write
  a_r4_timeout_write: assert property (@(posedge clk) disable iff (rst)
    (done && tout) |-> is_wr);
  // R10: serial lines quiet while idle
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!sk && !di));
  // R1: latched command is untouched during a transfer
  a_r1_hold_cmd: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(addr) && $stable(is_wr) && $stable(wdata)));

  generate
    if (SETTLE > 1) begin : g_hold
      // R11: a clock level change is followed by a held level
      a_r11_sk_hold: assert property (@(posedge clk) disable iff (rst)
        !$stable(sk) |=> $stable(sk));
    end
  endgenerate
endmodule

// File: rtl/mw_eeprom_ctrl.sv
module mw_eeprom_ctrl import mw_pkg::*; #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int SETTLE = 50,
  parameter int POLL_MAX = 200,
  parameter logic [2:0] OP_RD  = 3'b110,
  parameter logic [2:0] OP_WR  = 3'b101,
  parameter logic [4:0] OP_EN  = 5'b10011,
  parameter logic [4:0] OP_DIS = 5'b10000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_timeout,
  output logic              busy,
  output logic              ee_cs,
  output logic              ee_sk,
  output logic              ee_di,
  input  logic              ee_do
);
  localparam int FW = 3 + ADDR_W + DATA_W;
  localparam int LW = $clog2(FW + 1);

  logic              tick;
  logic              is_wr;
  logic [PC_W-1:0]   pc_nx;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  seg_e              nseg;
  logic [FW-1:0]     nbits;
  logic [LW-1:0]     nlen;

  assign req_ready = !busy;

  mw_tick #(.DIV(SETTLE)) u_tick (
    .clk(clk), .rst(rst), .en(busy), .tick(tick)
  );

  mw_prog #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FW(FW), .LW(LW),
    .OP_RD(OP_RD), .OP_WR(OP_WR), .OP_EN(OP_EN), .OP_DIS(OP_DIS)
  ) u_prog (
    .is_wr(is_wr), .pc(pc_nx), .addr(addr_q), .wdata(wdata_q),
    .seg(nseg), .bits(nbits), .len(nlen)
  );

  mw_engine #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FW(FW), .LW(LW),
    .SETTLE(SETTLE), .POLL_MAX(POLL_MAX)
  ) u_engine (
    .clk(clk), .rst(rst), .tick(tick),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .ee_do(ee_do), .nseg(nseg), .nbits(nbits), .nlen(nlen),
    .busy(busy), .is_wr(is_wr), .pc_nx(pc_nx),
    .addr(addr_q), .wdata(wdata_q),
    .done(rsp_valid), .rdata(rsp_rdata), .tout(rsp_timeout),
    .cs(ee_cs), .sk(ee_sk), .di(ee_di)
  );
endmodule

// File: tb/sim_mw_eeprom_ctrl.sv
module sim_mw_eeprom_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int S  = 4;
  localparam int PM = 8;
  localparam int B  = 24;
  localparam int L_RD = 66 * S;
  localparam int L_WR = (149 + 3) * S;
  localparam int L_TO = (149 + PM) * S;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rst, req_valid, req_ready, req_write;
  logic [5:0] req_addr;
  logic [15:0] req_wdata, rsp_rdata;
  logic rsp_valid, rsp_timeout, busy, ee_cs, ee_sk, ee_di, ee_do;

  mw_eeprom_ctrl #(.SETTLE(S), .POLL_MAX(PM)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_timeout(rsp_timeout),
    .busy(busy), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
  );

  int checks = 0;
  int errs = 0;

  // device model
  logic [15:0] mem [0:63];
  logic sk_p, cs_p, rd_act, wen, wr_pend, wait_m, never;
  logic [5:0] ra, wa;
  logic [3:0] rbit;
  logic [15:0] wd;
  logic [31:0] dsh, ns;
  int dcnt, nc, wcnt, ncmd;
  int hold, sk_viol;

  assign ee_do = rd_act ? mem[ra][rbit] : (wait_m && !never && wcnt >= B);

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 64; i++) mem[i] <= 16'h0;
      sk_p <= 1'b0; cs_p <= 1'b0; rd_act <= 1'b0; wen <= 1'b0;
      wr_pend <= 1'b0; wait_m <= 1'b0; dcnt <= 0; dsh <= '0;
      wcnt <= 0; ncmd <= 0; ra <= '0; wa <= '0; wd <= '0; rbit <= '0;
    end else begin
      sk_p <= ee_sk;
      cs_p <= ee_cs;
      if (ee_cs && !cs_p) begin dcnt <= 0; rd_act <= 1'b0; end
      if (cs_p && !ee_cs && wr_pend) begin
        wr_pend <= 1'b0;
        if (wen) mem[wa] <= wd;
        wait_m <= 1'b1;
        wcnt <= 0;
      end else if (wait_m && wcnt < 100000) wcnt <= wcnt + 1;
      if (ee_sk && !sk_p && ee_cs) begin
        nc = dcnt + 1;
        ns = {dsh[30:0], ee_di};
        dcnt <= nc;
        dsh <= ns;
        wait_m <= 1'b0;
        if (nc == 9) begin
          if (ns[8:6] == 3'b110) begin
            rd_act <= 1'b1; ra <= ns[5:0]; rbit <= 4'd15; ncmd <= ncmd + 1;
          end else if (ns[8:4] == 5'b10011) begin
            wen <= 1'b1; ncmd <= ncmd + 1;
          end else if (ns[8:4] == 5'b10000) begin
            wen <= 1'b0; ncmd <= ncmd + 1;
          end
        end else if (nc >= 10 && nc <= 25 && rd_act) begin
          rbit <= 4'(25 - nc);
        end
        if (nc == 25 && ns[24:22] == 3'b101) begin
          wr_pend <= 1'b1; wa <= ns[21:16]; wd <= ns[15:0]; ncmd <= ncmd + 1;
        end
      end
    end
  end

  // clock level hold monitor for R11
  always @(posedge clk) begin
    if (rst) begin hold <= 100; sk_viol <= 0; end
    else if (ee_sk != sk_p) begin
      if (hold < S) sk_viol <= sk_viol + 1;
      hold <= 1;
    end else hold <= hold + 1;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] pat(input int a);
    return 16'(a * 16'h0407) ^ 16'hC3A5;
  endfunction

  int lat;
  logic [15:0] rd;
  logic to, d_cs, d_sk, d_di, d_rdy;

  task automatic txn(input logic wr, input logic [5:0] a, input logic [15:0] d, input bit poke);
    int n;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    n = 0;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid && n < 5000) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (poke && n == 20) begin
        req_valid = 1'b1; req_write = 1'b1; req_addr = 6'd6; req_wdata = 16'h1234;
        chk(req_ready == 1'b0, "R1 ready low while busy", 32'(req_ready), 0);
      end
      if (poke && n == 30) req_valid = 1'b0;
    end
    lat = n; rd = rsp_rdata; to = rsp_timeout;
    d_cs = ee_cs; d_sk = ee_sk; d_di = ee_di; d_rdy = req_ready;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R9 response pulse one cycle", 32'(rsp_valid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    never = 1'b0;
    rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk({ee_cs, ee_sk, ee_di, busy, rsp_valid} == 5'b0, "R10 outputs low after reset",
        32'({ee_cs, ee_sk, ee_di, busy, rsp_valid}), 0);
    chk(req_ready == 1'b1, "R10 ready after reset", 32'(req_ready), 1);

    // R3 R4 R5 R8: write sweep over every address
    for (int a = 0; a < 64; a++) begin
      txn(1'b1, 6'(a), pat(a), 1'b0);
      chk(lat == L_WR, "R8 write latency", 32'(lat), 32'(L_WR));
      chk(to == 1'b0, "R9 write timeout clear", 32'(to), 0);
      chk({d_cs, d_sk, d_di} == 3'b000, "R5 pins low after write", 32'({d_cs, d_sk, d_di}), 0);
      chk(d_rdy == 1'b1, "R9 ready with response", 32'(d_rdy), 1);
      chk(mem[a] == pat(a), "R3 word stored", 32'(mem[a]), 32'(pat(a)));
      chk(wen == 1'b0, "R5 disable sent", 32'(wen), 0);
    end

    // R2 R6 R7 R8: read sweep
    for (int a = 0; a < 64; a++) begin
      txn(1'b0, 6'(a), 16'h0, 1'b0);
      chk(rd == pat(a), "R2 read data", 32'(rd), 32'(pat(a)));
      chk(lat == L_RD, "R8 read latency", 32'(lat), 32'(L_RD));
      chk(to == 1'b0, "R9 read timeout clear", 32'(to), 0);
      chk({d_cs, d_sk} == 2'b10, "R6 standby at read end", 32'({d_cs, d_sk}), 32'(2'b10));
      chk(d_di == 1'b0, "R7 data line low after read", 32'(d_di), 0);
    end

    // R2 R3: boundary data patterns
    txn(1'b1, 6'd62, 16'hFFFF, 1'b0);
    txn(1'b1, 6'd63, 16'h0000, 1'b0);
    txn(1'b1, 6'd0, 16'h8001, 1'b0);
    txn(1'b0, 6'd62, 16'h0, 1'b0);
    chk(rd == 16'hFFFF, "R2 all ones", 32'(rd), 32'hFFFF);
    txn(1'b0, 6'd63, 16'h0, 1'b0);
    chk(rd == 16'h0000, "R2 all zeros", 32'(rd), 0);
    txn(1'b0, 6'd0, 16'h0, 1'b0);
    chk(rd == 16'h8001, "R2 end bits", 32'(rd), 32'h8001);

    // R1: request while busy is ignored
    begin
      int c0;
      c0 = ncmd;
      txn(1'b0, 6'd5, 16'h0, 1'b1);
      chk(rd == pat(5), "R1 read during poke", 32'(rd), 32'(pat(5)));
      chk(lat == L_RD, "R1 latency unchanged", 32'(lat), 32'(L_RD));
      chk(ncmd == c0 + 1, "R1 single device command", 32'(ncmd), 32'(c0 + 1));
      chk(mem[6] == pat(6), "R1 poked word untouched", 32'(mem[6]), 32'(pat(6)));
    end

    // R4: device never ready
    never = 1'b1;
    txn(1'b1, 6'd9, 16'hBEEF, 1'b0);
    chk(to == 1'b1, "R4 timeout flagged", 32'(to), 1);
    chk(lat == L_TO, "R4 R8 timeout latency", 32'(lat), 32'(L_TO));
    chk(wen == 1'b0, "R5 disable after timeout", 32'(wen), 0);
    never = 1'b0;
    txn(1'b0, 6'd9, 16'h0, 1'b0);
    chk(to == 1'b0, "R9 timeout cleared on read", 32'(to), 0);
    chk(rd == 16'hBEEF, "R3 word after slow write", 32'(rd), 32'hBEEF);

    chk(sk_viol == 0, "R11 clock level hold", 32'(sk_viol), 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule